// File: doc/BRIEF.md
# Pre/Post Trigger Ring Capture

This block captures a transient around an event. Samples that arrive with a valid strobe go into a circular memory without pause, and once every slot has been written the newest sample replaces the oldest. A trigger does not start the recording. It marks the current sample as the trigger sample and then allows a programmed number P of further samples into the memory. After that, writing stops and the capture is done.

When the capture is done, the memory holds DEPTH−P samples up to and including the trigger sample, followed by the P samples that came after it. The block reports three things: the address of the last sample written (the stop pointer), the address of the trigger sample, and a flag that says whether every slot was written since the last re-arm. This flag tells a reader whether the oldest history is real data. A readback index counts from the oldest entry, so the record reads out in time order. A single-cycle re-arm pulse clears the result and starts a new capture.

Top module: `ringcap`

## Requirements
- R1: While armed, each sample accepted with `smp_valid_i`=1 is written to the write position, and the position then advances by one modulo DEPTH. After re-arm, the k-th accepted sample (counting from 0) lands at address k mod DEPTH.
- R2: The trigger sample is a sample accepted with `trig_i`=1 while armed. After it, exactly `post_cnt_i`=P further accepted samples are written, and then `done_o` goes to 1.
- R3: When done, `trig_ptr_o` holds the trigger sample's address and `stop_ptr_o` holds the last written address, with `trig_ptr_o` = (`stop_ptr_o` − P) mod DEPTH.
- R4: While done, incoming samples are not written, so the memory contents stay as they were.
- R5: `trig_i` has no effect after the trigger sample, either while the post-trigger samples are being collected or while done.
- R6: `trig_i` is ignored in any cycle where `smp_valid_i`=0.
- R7: `filled_o` goes to 1 when address DEPTH−1 is written, stays at 1 until re-arm, and is 0 after reset and after re-arm.
- R8: After reset, `done_o`, `filled_o`, `stop_ptr_o` and `trig_ptr_o` are 0. `done_o` and both pointers hold their values until `rearm_i`=1. Re-arm clears all of them and moves the write position back to address 0.
- R9: `rd_data_o` returns, one cycle after `rd_idx_i` is set, the entry at address (`stop_ptr_o`+1+`rd_idx_i`) mod DEPTH. Index 0 is the oldest entry, and the trigger sample is at index DEPTH−1−P.
- R10: With P=0, the capture stops on the trigger sample itself, and both pointers are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rearm_i | input | 1 | One-cycle pulse that starts a new capture |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DATA_W | Sample value |
| trig_i | input | 1 | Trigger event, qualified by the sample strobe |
| post_cnt_i | input | ADDR_W | Number of samples to keep after the trigger sample (0..DEPTH−1) |
| rd_idx_i | input | ADDR_W | Readback index, counted from the oldest entry |
| rd_data_o | output | DATA_W | Readback data, one cycle after the index |
| done_o | output | 1 | Capture complete |
| filled_o | output | 1 | Every slot written since re-arm |
| stop_ptr_o | output | ADDR_W | Address of the last written sample |
| trig_ptr_o | output | ADDR_W | Address of the trigger sample |

## Verification
The hardest situation to reach from the ports is a wrapped buffer in which triggers keep arriving during the post-trigger window, some of them in cycles with no valid sample. A retrigger or a stray write in that window shows up only as a shifted pointer or one stale word. The stimulus uses pretrigger runs longer than DEPTH and raises the trigger on every post-trigger sample and on the empty cycles between them. It then keeps sending samples after completion and reads back all DEPTH entries. Each entry is compared with a value predicted from its sample sequence number.

// File: rtl/ringcap_pkg.sv
package ringcap_pkg;
    typedef enum logic [1:0] {
        CAP_ARMED = 2'd0,
        CAP_POST  = 2'd1,
        CAP_DONE  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/ringcap_ctrl.sv
module ringcap_ctrl
    import ringcap_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rearm_i,
    input  logic              smp_valid_i,
    input  logic              trig_i,
    input  logic [ADDR_W-1:0] post_cnt_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              done_o,
    output logic              filled_o,
    output logic [ADDR_W-1:0] stop_ptr_o,
    output logic [ADDR_W-1:0] trig_ptr_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        cap_state_e        state;
        logic [ADDR_W-1:0] wr_ptr;
        logic [ADDR_W-1:0] left;
        logic [ADDR_W-1:0] cap_post;
        logic [ADDR_W-1:0] stop_ptr;
        logic [ADDR_W-1:0] trig_ptr;
        logic              filled;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  wr_en_d;

    always_comb begin
        ctl_d   = ctl_q;
        wr_en_d = 1'b0;
        if (rearm_i) begin
            ctl_d = '0;
        end else begin
            case (ctl_q.state)
                CAP_ARMED: begin
                    if (smp_valid_i) begin
                        wr_en_d      = 1'b1;
                        ctl_d.wr_ptr = ctl_q.wr_ptr + 1'b1;
                        if (ctl_q.wr_ptr == LAST_ADDR) ctl_d.filled = 1'b1;
                        if (trig_i) begin
                            ctl_d.trig_ptr = ctl_q.wr_ptr;
                            ctl_d.cap_post = post_cnt_i;
                            if (post_cnt_i == '0) begin
                                ctl_d.state    = CAP_DONE;
                                ctl_d.stop_ptr = ctl_q.wr_ptr;
                            end else begin
                                ctl_d.state = CAP_POST;
                                ctl_d.left  = post_cnt_i;
                            end
                        end
                    end
                end
                CAP_POST: begin
                    if (smp_valid_i) begin
                        wr_en_d      = 1'b1;
                        ctl_d.wr_ptr = ctl_q.wr_ptr + 1'b1;
                        ctl_d.left   = ctl_q.left - 1'b1;
                        if (ctl_q.wr_ptr == LAST_ADDR) ctl_d.filled = 1'b1;
                        if (ctl_q.left == {{(ADDR_W-1){1'b0}}, 1'b1}) begin
                            ctl_d.state    = CAP_DONE;
                            ctl_d.stop_ptr = ctl_q.wr_ptr;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wr_en_o    = wr_en_d;
    assign wr_addr_o  = ctl_q.wr_ptr;
    assign done_o     = (ctl_q.state == CAP_DONE);
    assign filled_o   = ctl_q.filled;
    assign stop_ptr_o = ctl_q.stop_ptr;
    assign trig_ptr_o = ctl_q.trig_ptr;

    logic [ADDR_W-1:0] span;
    assign span = ctl_q.stop_ptr - ctl_q.trig_ptr;

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !rearm_i) |=> (wr_addr_o == $past(wr_addr_o) + 1'b1)); // R1
    AST_STOP_TRIG_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (span == ctl_q.cap_post)); // R3
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.state == CAP_POST) && !rearm_i) |=> $stable(trig_ptr_o)); // R5
    AST_FILLED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (filled_o && !rearm_i) |=> filled_o); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rearm_i) |=> (done_o && $stable(stop_ptr_o) && $stable(trig_ptr_o))); // R8
    AST_REARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (!done_o && !filled_o && wr_addr_o == '0)); // R8
    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o || $stable(wr_addr_o))); // R4
endmodule

// File: rtl/ringcap_mem.sv
module ringcap_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) store_q[waddr_i] <= wdata_i;
        rdata_q <= store_q[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/ringcap.sv
module ringcap #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rearm_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              trig_i,
    input  logic [ADDR_W-1:0] post_cnt_i,
    input  logic [ADDR_W-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              filled_o,
    output logic [ADDR_W-1:0] stop_ptr_o,
    output logic [ADDR_W-1:0] trig_ptr_o
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    ringcap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rearm_i    (rearm_i),
        .smp_valid_i(smp_valid_i),
        .trig_i     (trig_i),
        .post_cnt_i (post_cnt_i),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .done_o     (done_o),
        .filled_o   (filled_o),
        .stop_ptr_o (stop_ptr_o),
        .trig_ptr_o (trig_ptr_o)
    );

    // oldest entry sits just past the stop pointer
    assign rd_addr = stop_ptr_o + {{(ADDR_W-1){1'b0}}, 1'b1} + rd_idx_i;

    ringcap_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk    (clk),
        .we_i   (wr_en),
        .waddr_i(wr_addr),
        .wdata_i(smp_data_i),
        .raddr_i(rd_addr),
        .rdata_o(rd_data_o)
    );

    AST_DONE_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_en); // R4
endmodule

// File: tb/ringcap_tb.sv
module ringcap_tb;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rearm = 1'b0;
    logic              valid = 1'b0;
    logic [DATA_W-1:0] data = '0;
    logic              trig = 1'b0;
    logic [ADDR_W-1:0] post = '0;
    logic [ADDR_W-1:0] rd_idx = '0;
    logic [DATA_W-1:0] rd_data;
    logic              done, filled;
    logic [ADDR_W-1:0] stop_ptr, trig_ptr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ringcap #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rearm_i(rearm), .smp_valid_i(valid),
        .smp_data_i(data), .trig_i(trig), .post_cnt_i(post), .rd_idx_i(rd_idx),
        .rd_data_o(rd_data), .done_o(done), .filled_o(filled),
        .stop_ptr_o(stop_ptr), .trig_ptr_o(trig_ptr)
    );

    // {pretrigger samples N, post count P, trigger on post samples, idle gaps}
    localparam logic [31:0] VEC [6] = '{
        {8'd3,  8'd4,  8'd0, 8'd0},
        {8'd20, 8'd5,  8'd1, 8'd0},
        {8'd0,  8'd0,  8'd0, 8'd0},
        {8'd10, 8'd15, 8'd1, 8'd1},
        {8'd15, 8'd0,  8'd0, 8'd1},
        {8'd1,  8'd14, 8'd1, 8'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic t, input int d);
        @(negedge clk);
        valid = v; trig = t; data = DATA_W'(d);
    endtask

    task automatic idle();
        @(negedge clk);
        valid = 1'b0; trig = 1'b0;
    endtask

    task automatic do_rearm();
        @(negedge clk);
        rearm = 1'b1; valid = 1'b0; trig = 1'b0;
        @(negedge clk);
        rearm = 1'b0;
    endtask

    function automatic int sval(input int v, input int s);
        return (v << 8) | s;
    endfunction

    task automatic run_vec(input int v, input int n, input int p, input int xt, input int gp);
        int last;
        post = ADDR_W'(p);
        do_rearm();
        check("R8 done clear", int'(done), 0);
        for (int s = 0; s < n; s++) drive(1'b1, 1'b0, sval(v, s));
        drive(1'b1, 1'b1, sval(v, n));
        for (int j = 1; j <= p; j++) begin
            if (gp != 0) drive(1'b0, 1'b1, 0);              // R6 / R5 stray trigger
            drive(1'b1, xt[0], sval(v, n + j));             // R5 retrigger
        end
        last = n + p;
        for (int e = 1; e <= 3; e++) drive(1'b1, 1'b1, sval(v, last + e)); // R4
        idle();
        check("R2 done", int'(done), 1);
        check("R3 trig_ptr", int'(trig_ptr), n % DEPTH);
        check("R3 stop_ptr", int'(stop_ptr), last % DEPTH);
        check("R7 filled", int'(filled), (last >= DEPTH - 1) ? 1 : 0);
        if (p == 0) check("R10 ptrs equal", int'(trig_ptr), int'(stop_ptr));
        for (int k = 0; k < DEPTH; k++) begin
            int seq;
            @(negedge clk);
            rd_idx = ADDR_W'(k);
            @(negedge clk);
            seq = last - (DEPTH - 1) + k;
            if (seq >= 0) check("R9 R4 R1 readback", int'(rd_data), sval(v, seq));
        end
        check("R8 done hold", int'(done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset done", int'(done), 0);
        check("R8 reset filled", int'(filled), 0);
        check("R8 reset stop", int'(stop_ptr), 0);
        check("R8 reset trig", int'(trig_ptr), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++)
            run_vec(i, int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                    int'(VEC[i][15:8]), int'(VEC[i][7:0]));

        // directed: re-arm clears, trigger without valid ignored, trigger when done ignored
        post = '0;
        do_rearm();
        check("R8 rearm done", int'(done), 0);
        check("R7 rearm filled", int'(filled), 0);
        drive(1'b0, 1'b1, 0);
        idle();
        check("R6 no valid no trigger", int'(done), 0);
        drive(1'b1, 1'b0, sval(9, 0));
        drive(1'b1, 1'b0, sval(9, 1));
        drive(1'b1, 1'b1, sval(9, 2));
        idle();
        check("R10 done at trigger", int'(done), 1);
        check("R6 trig_ptr", int'(trig_ptr), 2);
        check("R10 stop_ptr", int'(stop_ptr), 2);
        post = 4'd5;
        drive(1'b1, 1'b1, sval(9, 3));
        idle();
        repeat (4) @(negedge clk);
        check("R5 trig_ptr after done", int'(trig_ptr), 2);
        check("R8 stop hold", int'(stop_ptr), 2);
        check("R5 done hold", int'(done), 1);
        @(negedge clk);
        rd_idx = ADDR_W'(DEPTH - 1);
        @(negedge clk);
        check("R9 trigger sample last", int'(rd_data), sval(9, 2));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule